// File: doc/BRIEF.md
# Ethernet transmit frame builder

This block turns an outgoing packet, delivered one byte at a time over a stream handshake, into a complete Ethernet frame on a byte-wide transmit path towards the PHY. The upstream packet carries the destination address and then the EtherType, but no source address. The block adds a preamble and start-of-frame delimiter in front. It splices the local source address in after the destination field. It zero-pads runt frames up to the Ethernet minimum and closes each frame with the CRC-32 frame check sequence.

The block emits its own bytes (preamble, source address, padding, check sequence) and enforces the inter-frame gap. While it does so, it holds its ready output low, so consecutive packets can never run together into one frame. The source of the packet is expected to keep `s_tvalid` high from the first byte to the last byte. The output then carries one byte every cycle from the first preamble byte to the last check byte.

Top module: `eth_frame_tx`

## Requirements
- R1: Every frame starts on `tx_data_o` with exactly PRE_LEN (default 7) bytes of 0x55, followed by one byte 0xD5.
- R2: After the delimiter, the first 6 accepted input bytes appear unchanged. Then come the 6 source-address bytes, with bits 47:40 first and bits 7:0 last. Then the remaining input bytes (EtherType onwards) appear unchanged and in order.
- R3: When the bytes from the destination address through the last data byte number fewer than MIN_FRAME-4 (default 60), zero bytes are appended until there are exactly MIN_FRAME-4. Longer frames get no padding.
- R4: The last 4 bytes of a frame are the check sequence, computed over all bytes from the destination address through the padding. The CRC is reflected, with polynomial 0x04C11DB7 (0xEDB88320 in reflected form), initial value 0xFFFFFFFF and a final inversion. It is sent least-significant byte first.
- R5: `src_mac_i` is sampled when a frame starts. Changes made to it after the first packet byte is accepted do not affect that frame.
- R6: `s_tready` is low while the block sends the preamble, source address, padding and check sequence, and during the gap. In the cycle after the byte carrying `s_tlast` is accepted, `s_tready` is low, so back-to-back packets leave as separate frames.
- R7: Between the last check byte of one frame and the first preamble byte of the next, `tx_valid_o` is low for at least IFG_LEN (default 12) cycles.
- R8: With `s_tvalid` held high through a packet, `tx_valid_o` stays high on every cycle from the first preamble byte to the last check byte. The frame length is PRE_LEN+1+max(MIN_FRAME-4, n+6)+4 bytes for an n-byte input packet.
- R9: During and right after reset, `tx_valid_o` and `s_tready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_mac_i | input | 48 | Local source address, sampled at frame start |
| s_tvalid | input | 1 | Input byte valid |
| s_tready | output | 1 | Block accepts an input byte this cycle |
| s_tdata | input | 8 | Input packet byte |
| s_tlast | input | 1 | Marks the final byte of a packet |
| tx_valid_o | output | 1 | A frame byte is present on tx_data_o |
| tx_data_o | output | 8 | Frame byte towards the PHY |

## Verification
Directed packets sit at the padding edges: an 8-byte packet (the largest padding), 53 bytes (one pad byte), 54 bytes (exactly at the minimum) and 55 bytes (one past it). These separate an off-by-one in the pad decision from a fault in the CRC, which covers the pad bytes. Packets sent back to back with `s_tvalid` never dropping test that frames stay apart, that the gap holds, and that ready falls after the last byte. Randomly sized packets with random contents and addresses, some with the address input changed mid-frame, exercise the splice position, the sampling point of the address and the byte order of the check sequence.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_PRE,
      ST_SFD,
      ST_DST,
      ST_SRC,
      ST_BODY,
      ST_PAD,
      ST_FCS,
      ST_GAP
   } tx_state_e;

   localparam logic [7:0]  PRE_BYTE   = 8'h55;
   localparam logic [7:0]  SFD_BYTE   = 8'hD5;
   localparam logic [31:0] CRC_POLY_R = 32'hEDB88320;
   localparam logic [31:0] CRC_INIT   = 32'hFFFFFFFF;
   localparam int          MAC_BYTES  = 6;
   localparam int          FCS_BYTES  = 4;

endpackage

// File: rtl/frm_crc32.sv
module frm_crc32
   import eth_tx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              en,
   input  logic [DATA_W-1:0] din,
   output logic [31:0]       crc_q
);

   initial assert (DATA_W >= 1 && DATA_W <= 32)
      else $error("frm_crc32: DATA_W out of range");

   logic [31:0] stg [0:DATA_W];

   assign stg[0] = crc_q ^ {{(32-DATA_W){1'b0}}, din};

   for (genvar g = 0; g < DATA_W; g++) begin : g_bit
      assign stg[g+1] = stg[g][0] ? ((stg[g] >> 1) ^ CRC_POLY_R) : (stg[g] >> 1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         crc_q <= CRC_INIT;
      end else if (clr) begin
         crc_q <= CRC_INIT;
      end else if (en) begin
         crc_q <= stg[DATA_W];
      end
   end

endmodule

// File: rtl/frm_macsel.sv
module frm_macsel
   import eth_tx_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        load,
   input  logic [47:0] mac_i,
   input  logic [2:0]  idx,
   output logic [7:0]  mac_byte_o
);

   logic [47:0] mac_q;
   logic [7:0]  mac_b [0:7];

   for (genvar g = 0; g < 8; g++) begin : g_byte
      if (g < MAC_BYTES) begin : g_real
         assign mac_b[g] = mac_q[47-8*g -: 8];
      end else begin : g_none
         assign mac_b[g] = 8'h00;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mac_q <= '0;
      end else if (load) begin
         mac_q <= mac_i;
      end
   end

   assign mac_byte_o = mac_b[idx];

endmodule

// File: rtl/frm_seq.sv
module frm_seq
   import eth_tx_pkg::*;
#(
   parameter int PRE_LEN   = 7,
   parameter int MIN_FRAME = 64,
   parameter int IFG_LEN   = 12
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        s_tvalid,
   input  logic        s_tlast,
   input  logic [7:0]  s_tdata,
   output logic        s_tready,
   input  logic [7:0]  mac_byte,
   output logic [2:0]  mac_idx,
   output logic        mac_load,
   input  logic [31:0] crc,
   output logic        crc_clr,
   output logic        crc_en,
   output logic        emit,
   output logic [7:0]  emit_byte
);

   localparam int DATA_MIN = MIN_FRAME - FCS_BYTES;
   localparam int CNT_MAX  = (PRE_LEN > IFG_LEN)
                           ? ((PRE_LEN > MAC_BYTES) ? PRE_LEN : MAC_BYTES)
                           : ((IFG_LEN > MAC_BYTES) ? IFG_LEN : MAC_BYTES);
   localparam int CW = $clog2(CNT_MAX + 1);
   localparam int LW = $clog2(DATA_MIN + 1);

   initial assert (PRE_LEN >= 1) else $error("frm_seq: PRE_LEN must be >= 1");
   initial assert (IFG_LEN >= 1) else $error("frm_seq: IFG_LEN must be >= 1");
   initial assert (DATA_MIN > 2*MAC_BYTES + 2)
      else $error("frm_seq: MIN_FRAME too small for the header");

   tx_state_e     st_q, st_d;
   logic [CW-1:0] cnt_q, cnt_d;
   logic [LW-1:0] len_q;
   logic [LW:0]   len_nx;
   logic          ended_q, ended_set, len_clr, len_inc, last_data;

   assign len_nx    = {1'b0, len_q} + {{LW{1'b0}}, 1'b1};
   assign last_data = (len_nx >= (LW+1)'(DATA_MIN));
   assign mac_idx   = cnt_q[2:0];

   always_comb begin
      st_d      = st_q;
      cnt_d     = cnt_q;
      s_tready  = 1'b0;
      emit      = 1'b0;
      emit_byte = 8'h00;
      crc_clr   = 1'b0;
      crc_en    = 1'b0;
      mac_load  = 1'b0;
      len_clr   = 1'b0;
      len_inc   = 1'b0;
      ended_set = 1'b0;
      case (st_q)
         ST_IDLE: begin
            crc_clr = 1'b1;
            if (s_tvalid) begin
               mac_load = 1'b1;
               st_d     = ST_PRE;
               cnt_d    = '0;
            end
         end
         ST_PRE: begin
            emit      = 1'b1;
            emit_byte = PRE_BYTE;
            if (cnt_q == CW'(PRE_LEN - 1)) begin
               st_d = ST_SFD;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         ST_SFD: begin
            emit      = 1'b1;
            emit_byte = SFD_BYTE;
            len_clr   = 1'b1;
            st_d      = ST_DST;
            cnt_d     = '0;
         end
         ST_DST: begin
            s_tready = 1'b1;
            if (s_tvalid) begin
               emit      = 1'b1;
               emit_byte = s_tdata;
               crc_en    = 1'b1;
               len_inc   = 1'b1;
               if (s_tlast || cnt_q == CW'(MAC_BYTES - 1)) begin
                  ended_set = s_tlast;
                  st_d      = ST_SRC;
                  cnt_d     = '0;
               end else begin
                  cnt_d = cnt_q + 1'b1;
               end
            end
         end
         ST_SRC: begin
            emit      = 1'b1;
            emit_byte = mac_byte;
            crc_en    = 1'b1;
            len_inc   = 1'b1;
            if (cnt_q == CW'(MAC_BYTES - 1)) begin
               st_d  = ended_q ? ST_PAD : ST_BODY;
               cnt_d = '0;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         ST_BODY: begin
            s_tready = 1'b1;
            if (s_tvalid) begin
               emit      = 1'b1;
               emit_byte = s_tdata;
               crc_en    = 1'b1;
               len_inc   = 1'b1;
               if (s_tlast) begin
                  st_d  = last_data ? ST_FCS : ST_PAD;
                  cnt_d = '0;
               end
            end
         end
         ST_PAD: begin
            emit      = 1'b1;
            emit_byte = 8'h00;
            crc_en    = 1'b1;
            len_inc   = 1'b1;
            if (last_data) begin
               st_d  = ST_FCS;
               cnt_d = '0;
            end
         end
         ST_FCS: begin
            emit      = 1'b1;
            emit_byte = ~crc[8*cnt_q[1:0] +: 8];
            if (cnt_q == CW'(FCS_BYTES - 1)) begin
               st_d  = ST_GAP;
               cnt_d = '0;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         ST_GAP: begin
            if (cnt_q == CW'(IFG_LEN - 1)) begin
               st_d = ST_IDLE;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         cnt_q   <= '0;
         len_q   <= '0;
         ended_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         cnt_q <= cnt_d;
         if (len_clr) begin
            len_q <= '0;
         end else if (len_inc && len_q != LW'(DATA_MIN)) begin
            len_q <= len_q + 1'b1;
         end
         if (len_clr) begin
            ended_q <= 1'b0;
         end else if (ended_set) begin
            ended_q <= 1'b1;
         end
      end
   end

   // R6
   tready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s_tvalid && s_tready && s_tlast) |=> !s_tready);

   // R3
   min_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_FCS && cnt_q == '0) |-> (len_q >= LW'(DATA_MIN)));

   // R2
   src_after_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_SRC && cnt_q == '0) |-> (len_q == LW'(MAC_BYTES) || ended_q));

endmodule

// File: rtl/eth_frame_tx.sv
module eth_frame_tx
   import eth_tx_pkg::*;
#(
   parameter int PRE_LEN   = 7,
   parameter int MIN_FRAME = 64,
   parameter int IFG_LEN   = 12
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [47:0] src_mac_i,
   input  logic        s_tvalid,
   output logic        s_tready,
   input  logic [7:0]  s_tdata,
   input  logic        s_tlast,
   output logic        tx_valid_o,
   output logic [7:0]  tx_data_o
);

   localparam int GW = $clog2(IFG_LEN + 1);

   logic [7:0]  mac_byte, emit_byte;
   logic [2:0]  mac_idx;
   logic [31:0] crc;
   logic        mac_load, crc_clr, crc_en, emit;

   frm_seq #(
      .PRE_LEN   (PRE_LEN),
      .MIN_FRAME (MIN_FRAME),
      .IFG_LEN   (IFG_LEN)
   ) seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .s_tvalid  (s_tvalid),
      .s_tlast   (s_tlast),
      .s_tdata   (s_tdata),
      .s_tready  (s_tready),
      .mac_byte  (mac_byte),
      .mac_idx   (mac_idx),
      .mac_load  (mac_load),
      .crc       (crc),
      .crc_clr   (crc_clr),
      .crc_en    (crc_en),
      .emit      (emit),
      .emit_byte (emit_byte)
   );

   frm_macsel mac_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (mac_load),
      .mac_i      (src_mac_i),
      .idx        (mac_idx),
      .mac_byte_o (mac_byte)
   );

   frm_crc32 #(.DATA_W(8)) crc_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (crc_clr),
      .en    (crc_en),
      .din   (emit_byte),
      .crc_q (crc)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_valid_o <= 1'b0;
         tx_data_o  <= 8'h00;
      end else begin
         tx_valid_o <= emit;
         tx_data_o  <= emit ? emit_byte : 8'h00;
      end
   end

   logic [GW-1:0] idle_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idle_q <= GW'(IFG_LEN);
      end else if (tx_valid_o) begin
         idle_q <= '0;
      end else if (idle_q != GW'(IFG_LEN)) begin
         idle_q <= idle_q + 1'b1;
      end
   end

   // R7
   ifg_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_valid_o) |-> (idle_q >= GW'(IFG_LEN)));

   // R1
   pre_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_valid_o) |-> (tx_data_o == PRE_BYTE));

endmodule

// File: tb/eth_frame_tx_tb.sv
module eth_frame_tx_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int PRE_LEN    = 7;
   localparam int MIN_FRAME  = 64;
   localparam int IFG_LEN    = 12;
   localparam int DATA_MIN   = MIN_FRAME - 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [47:0] src_mac_i = '0;
   logic        s_tvalid = 1'b0;
   logic        s_tready;
   logic [7:0]  s_tdata = '0;
   logic        s_tlast = 1'b0;
   logic        tx_valid_o;
   logic [7:0]  tx_data_o;

   always #(CLK_PERIOD/2) clk = ~clk;

   eth_frame_tx #(
      .PRE_LEN(PRE_LEN), .MIN_FRAME(MIN_FRAME), .IFG_LEN(IFG_LEN)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .src_mac_i(src_mac_i),
      .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata), .s_tlast(s_tlast),
      .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o)
   );

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   byte unsigned exp_flat[$];
   int           exp_len[$];
   int           exp_nin[$];
   bit           exp_mchg[$];
   byte unsigned got[$];
   int           idle_run = 0;
   bit           seen_frame = 1'b0;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] crc_of(input byte unsigned d[$]);
      logic [31:0] c = 32'hFFFFFFFF;
      foreach (d[i]) begin
         c = c ^ {24'h0, d[i]};
         for (int b = 0; b < 8; b++) begin
            if (c[0]) c = (c >> 1) ^ 32'hEDB88320;
            else      c = c >> 1;
         end
      end
      return ~c;
   endfunction

   // Expected frame built from R1..R4
   task automatic push_expected(input byte unsigned p[$], input logic [47:0] mac, input bit mchg);
      byte unsigned body[$];
      byte unsigned fr[$];
      logic [31:0]  fcs;
      for (int i = 0; i < 6; i++) body.push_back(p[i]);
      for (int i = 0; i < 6; i++) body.push_back(mac[47-8*i -: 8]);
      for (int i = 6; i < p.size(); i++) body.push_back(p[i]);
      while (body.size() < DATA_MIN) body.push_back(8'h00);
      fcs = crc_of(body);
      for (int i = 0; i < PRE_LEN; i++) fr.push_back(8'h55);
      fr.push_back(8'hD5);
      foreach (body[i]) fr.push_back(body[i]);
      for (int i = 0; i < 4; i++) fr.push_back(fcs[8*i +: 8]);
      foreach (fr[i]) exp_flat.push_back(fr[i]);
      exp_len.push_back(fr.size());
      exp_nin.push_back(p.size());
      exp_mchg.push_back(mchg);
   endtask

   task automatic region_check(input byte unsigned e[$], input int lo, input int hi,
                               input string req, input string what);
      int bad = -1;
      for (int i = lo; i < hi; i++) if (bad < 0 && got[i] != e[i]) bad = i;
      if (bad < 0) check(1'b1, req, what, 0, 0);
      else check(1'b0, req, $sformatf("%s byte %0d", what, bad), got[bad], e[bad]);
   endtask

   task automatic finish_frame();
      int L, nin;
      bit mchg;
      byte unsigned e[$];
      if (exp_len.size() == 0) begin
         check(1'b0, "R6", "unexpected frame", got.size(), 0);
         return;
      end
      L = exp_len.pop_front();
      nin = exp_nin.pop_front();
      mchg = exp_mchg.pop_front();
      for (int i = 0; i < L; i++) e.push_back(exp_flat.pop_front());
      check(got.size() == L, "R8", "frame length", got.size(), L);
      if (got.size() == L) begin
         region_check(e, 0, PRE_LEN + 1, "R1", "preamble");
         region_check(e, PRE_LEN + 1, PRE_LEN + 7, "R2", "destination");
         region_check(e, PRE_LEN + 7, PRE_LEN + 13, mchg ? "R5" : "R2", "source address");
         region_check(e, PRE_LEN + 13, PRE_LEN + 7 + nin, "R2", "payload");
         if (nin + 6 < DATA_MIN)
            region_check(e, PRE_LEN + 7 + nin, L - 4, "R3", "padding");
         region_check(e, L - 4, L, "R4", "check sequence");
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (tx_valid_o) begin
            if (got.size() == 0 && seen_frame)
               check(idle_run >= IFG_LEN, "R7", "inter-frame gap", idle_run, IFG_LEN);
            got.push_back(tx_data_o);
            idle_run = 0;
         end else begin
            idle_run++;
            if (got.size() > 0) begin
               finish_frame();
               got.delete();
               seen_frame = 1'b1;
            end
         end
      end
   end

   // Called and returns aligned to a falling edge
   task automatic send_pkt(input int n, input bit mchg);
      byte unsigned p[$];
      bit acc;
      for (int i = 0; i < n; i++) p.push_back(8'($urandom));
      push_expected(p, src_mac_i, mchg);
      for (int i = 0; i < n; i++) begin
         s_tvalid = 1'b1;
         s_tdata  = p[i];
         s_tlast  = (i == n - 1);
         do begin
            #1;
            acc = s_tready;
            @(negedge clk);
         end while (!acc);
         if (i == 0 && mchg) src_mac_i = ~src_mac_i;
      end
      s_tvalid = 1'b0;
      s_tlast  = 1'b0;
      #1;
      check(!s_tready, "R6", "ready after last byte", s_tready, 0);
   endtask

   task automatic new_mac();
      src_mac_i = {16'($urandom), 32'($urandom)};
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      check(!tx_valid_o && !s_tready, "R9", "outputs in reset", {tx_valid_o, s_tready}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!tx_valid_o && !s_tready, "R9", "outputs after reset", {tx_valid_o, s_tready}, 0);

      // Directed pad edges (R3)
      src_mac_i = 48'h0A1B2C3D4E5F;
      send_pkt(8, 1'b0);
      new_mac(); send_pkt(53, 1'b0);
      new_mac(); send_pkt(54, 1'b0);
      new_mac(); send_pkt(55, 1'b0);
      // Address change mid-frame (R5)
      new_mac(); send_pkt(150, 1'b1);
      new_mac(); send_pkt(9, 1'b1);
      // Back to back, valid never idles (R6, R7)
      for (int k = 0; k < 3; k++) begin
         new_mac();
         send_pkt(8 + int'($urandom % 80), 1'b0);
      end
      // Random mix
      for (int k = 0; k < 20; k++) begin
         new_mac();
         send_pkt(8 + int'($urandom % 120), 1'($urandom));
         repeat (int'($urandom % 6)) @(negedge clk);
      end

      while (exp_len.size() != 0) @(negedge clk);
      repeat (20) @(negedge clk);
      check(got.size() == 0 && exp_len.size() == 0, "R8", "frames left over",
            got.size() + exp_len.size(), 0);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, pending frames %0d", exp_len.size());
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule